// File: doc/BRIEF.md
# SHA-512 Sigma and Sum Function Unit

This block evaluates the four bit-mixing functions of SHA-512 for a processor datapath: the message-schedule functions σ0 and σ1, and the compression-round functions Σ0 and Σ1. It is purely combinational. The result depends only on the current inputs, and its latency is the same for every operand value.

In 64-bit mode one 64-bit source holds the whole word, and the unit returns the full 64-bit function value. In 32-bit mode the 64-bit word lies across two 32-bit register operands, and the unit returns one 32-bit half of the function value. Wherever a rotation or the shift crosses the half boundary, bits move between the two operands.

An operation code picks the function and the half. A `valid` output flags whether that code is legal in the current mode. Decode, the register file, the adders and the round state are outside the block. The interface carries no handshake: the block has no storage, so a result is present whenever its inputs are.

Top module: `sha512_mix_unit`

## Requirements
- R1: In 64-bit mode (`mode64`=1) with `op`=0, `result` = ROTR1(x) ^ ROTR8(x) ^ SHR7(x), where x = `rs1`. `valid`=1.
- R2: In 64-bit mode with `op`=1, `result` = ROTR19(x) ^ ROTR61(x) ^ SHR6(x), where x = `rs1`. `valid`=1.
- R3: In 64-bit mode, `op`=2 gives ROTR28^ROTR34^ROTR39 of `rs1` and `op`=3 gives ROTR14^ROTR18^ROTR41 of `rs1`. `valid`=1 for both.
- R4: In 32-bit mode (`mode64`=0), the high-half σ codes are `op`=4 (σ0) and `op`=6 (σ1). They form the word as {rs1[31:0], rs2[31:0]} and return bits 63:32 of the function value. The low-half σ codes are `op`=5 (σ0) and `op`=7 (σ1). They form the word as {rs2[31:0], rs1[31:0]} and return bits 31:0.
- R5: In 32-bit mode, `op`=8 (Σ0) and `op`=9 (Σ1) form the word as {rs1[31:0], rs2[31:0]} and return bits 63:32 of the function value. With the operands swapped, the same code returns bits 31:0.
- R6: In 32-bit mode, `rs1[63:32]` and `rs2[63:32]` have no effect. `result[63:32]` is zero.
- R7: Any code other than 0 to 3 in 64-bit mode, or other than 4 to 9 in 32-bit mode, drives `result` to zero and `valid` to 0.
- R8: The unit holds no state. `result` and `valid` follow the inputs within the same cycle, for every operand value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode64 | input | 1 | 1 selects 64-bit operations, 0 selects 32-bit half-operations |
| op | input | 4 | Operation code (see R1 to R7) |
| rs1 | input | 64 | First source; in 32-bit mode only bits 31:0 are read |
| rs2 | input | 64 | Second source; read only in 32-bit mode, bits 31:0 |
| result | output | 64 | Function value, or zero-extended half |
| valid | output | 1 | 1 when `op` is legal in the current mode |

## Verification
The hardest case is a bit that moves across the half boundary: a rotation or the shift carries it from one 32-bit operand into the half that is returned. This shows up only for particular bit positions. The stimulus therefore includes single-set-bit words at both sides of the boundary (bits 0, 31, 32 and 63) as well as random words. Each half-operation is applied in both operand orders, and the two 32-bit answers are joined and compared against a behavioural 64-bit reference. Junk is placed in the unused upper source bits so that any leakage shows in the result.

// File: rtl/sha512_mix_pkg.sv
package sha512_mix_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;

  // operation codes; 0..3 are 64-bit only, 4..9 are 32-bit half-ops
  localparam logic [3:0] OP_S0     = 4'd0;
  localparam logic [3:0] OP_S1     = 4'd1;
  localparam logic [3:0] OP_B0     = 4'd2;
  localparam logic [3:0] OP_B1     = 4'd3;
  localparam logic [3:0] OP_S0_HI  = 4'd4;
  localparam logic [3:0] OP_S0_LO  = 4'd5;
  localparam logic [3:0] OP_S1_HI  = 4'd6;
  localparam logic [3:0] OP_S1_LO  = 4'd7;
  localparam logic [3:0] OP_B0_PR  = 4'd8;
  localparam logic [3:0] OP_B1_PR  = 4'd9;

  // rotation and shift amounts of the four functions
  localparam int S0_A = 1,  S0_B = 8,  S0_C = 7;
  localparam int S1_A = 19, S1_B = 61, S1_C = 6;
  localparam int B0_A = 28, B0_B = 34, B0_C = 39;
  localparam int B1_A = 14, B1_B = 18, B1_C = 41;

  typedef enum logic [1:0] {FN_S0, FN_S1, FN_B0, FN_B1} fn_e;

  typedef struct packed {
    logic ok;
    fn_e  fn;
    logic low_half;
    logic swap;
  } dec_t;
endpackage

// File: rtl/sha512_mix_tree.sv
// Three-term XOR of rotations; the last term is a logical right shift when SHIFT_LAST is set.
module sha512_mix_tree #(
  parameter int W          = 64,
  parameter int ROT_A      = 1,
  parameter int ROT_B      = 8,
  parameter int AMT_C      = 7,
  parameter bit SHIFT_LAST = 1'b1
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [2*W-1:0] dbl;
  logic [W-1:0]   t_a, t_b, t_c;

  assign dbl = {x, x};
  assign t_a = dbl[ROT_A +: W];
  assign t_b = dbl[ROT_B +: W];

  generate
    if (SHIFT_LAST) begin : g_shift
      assign t_c = x >> AMT_C;
    end else begin : g_rot
      assign t_c = dbl[AMT_C +: W];
    end
  endgenerate

  assign y = t_a ^ t_b ^ t_c;
endmodule

// File: rtl/sha512_mix_decode.sv
// Maps mode and operation code to function, half and operand order.
module sha512_mix_decode
  import sha512_mix_pkg::*;
(
  input  logic       mode64,
  input  logic [3:0] op,
  output dec_t       dec
);
  always_comb begin
    dec = '{ok: 1'b0, fn: FN_S0, low_half: 1'b0, swap: 1'b0};
    if (mode64) begin
      unique case (op)
        OP_S0:   dec = '{ok: 1'b1, fn: FN_S0, low_half: 1'b0, swap: 1'b0};
        OP_S1:   dec = '{ok: 1'b1, fn: FN_S1, low_half: 1'b0, swap: 1'b0};
        OP_B0:   dec = '{ok: 1'b1, fn: FN_B0, low_half: 1'b0, swap: 1'b0};
        OP_B1:   dec = '{ok: 1'b1, fn: FN_B1, low_half: 1'b0, swap: 1'b0};
        default: ;
      endcase
    end else begin
      unique case (op)
        OP_S0_HI: dec = '{ok: 1'b1, fn: FN_S0, low_half: 1'b0, swap: 1'b0};
        OP_S0_LO: dec = '{ok: 1'b1, fn: FN_S0, low_half: 1'b1, swap: 1'b1};
        OP_S1_HI: dec = '{ok: 1'b1, fn: FN_S1, low_half: 1'b0, swap: 1'b0};
        OP_S1_LO: dec = '{ok: 1'b1, fn: FN_S1, low_half: 1'b1, swap: 1'b1};
        OP_B0_PR: dec = '{ok: 1'b1, fn: FN_B0, low_half: 1'b0, swap: 1'b0};
        OP_B1_PR: dec = '{ok: 1'b1, fn: FN_B1, low_half: 1'b0, swap: 1'b0};
        default:  ;
      endcase
    end
  end

  // R4: only the shift-bearing functions have a low-half code
  always_comb begin
    assert_lowhalf_sigma_R4: assert (!(dec.ok && dec.low_half) || dec.fn == FN_S0 || dec.fn == FN_S1);
  end
endmodule

// File: rtl/sha512_mix_unit.sv
module sha512_mix_unit
  import sha512_mix_pkg::*;
(
  input  logic              mode64,
  input  logic [3:0]        op,
  input  logic [WORD_W-1:0] rs1,
  input  logic [WORD_W-1:0] rs2,
  output logic [WORD_W-1:0] result,
  output logic              valid
);
  dec_t              dec;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] f_s0, f_s1, f_b0, f_b1, f_sel;
  logic [3:0]        fn_hot;

  sha512_mix_decode u_dec (.mode64(mode64), .op(op), .dec(dec));

  // operand assembly: full source, or the two low halves in chosen order
  always_comb begin
    if (mode64)        word = rs1;
    else if (dec.swap) word = {rs2[HALF_W-1:0], rs1[HALF_W-1:0]};
    else               word = {rs1[HALF_W-1:0], rs2[HALF_W-1:0]};
  end

  sha512_mix_tree #(.W(WORD_W), .ROT_A(S0_A), .ROT_B(S0_B), .AMT_C(S0_C), .SHIFT_LAST(1'b1))
    u_s0 (.x(word), .y(f_s0));
  sha512_mix_tree #(.W(WORD_W), .ROT_A(S1_A), .ROT_B(S1_B), .AMT_C(S1_C), .SHIFT_LAST(1'b1))
    u_s1 (.x(word), .y(f_s1));
  sha512_mix_tree #(.W(WORD_W), .ROT_A(B0_A), .ROT_B(B0_B), .AMT_C(B0_C), .SHIFT_LAST(1'b0))
    u_b0 (.x(word), .y(f_b0));
  sha512_mix_tree #(.W(WORD_W), .ROT_A(B1_A), .ROT_B(B1_B), .AMT_C(B1_C), .SHIFT_LAST(1'b0))
    u_b1 (.x(word), .y(f_b1));

  always_comb begin
    fn_hot = 4'b0000;
    if (dec.ok) fn_hot[dec.fn] = 1'b1;
  end

  assign f_sel = ({WORD_W{fn_hot[0]}} & f_s0) | ({WORD_W{fn_hot[1]}} & f_s1)
               | ({WORD_W{fn_hot[2]}} & f_b0) | ({WORD_W{fn_hot[3]}} & f_b1);

  always_comb begin
    if (mode64)            result = f_sel;
    else if (dec.low_half) result = {{HALF_W{1'b0}}, f_sel[HALF_W-1:0]};
    else                   result = {{HALF_W{1'b0}}, f_sel[WORD_W-1:HALF_W]};
  end

  assign valid = dec.ok;

  always_comb begin
    assert_onehot_fn_R8:   assert ($onehot0(fn_hot));
    assert_illegal_zero_R7: assert (valid || result == '0);
    assert_half_upper_R6:  assert (mode64 || result[WORD_W-1:HALF_W] == '0);
    assert_code_range_R7:  assert (!valid || (mode64 ? (op < 4'd4) : (op >= 4'd4 && op <= 4'd9)));
  end
endmodule

// File: tb/sha512_mix_unit_test.sv
module sha512_mix_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode64;
  logic [3:0]  op;
  logic [63:0] rs1, rs2, result;
  logic        valid;
  int          n_chk = 0, n_bad = 0;
  int          cycles = 0;

  always #5 clk = ~clk;

  sha512_mix_unit uut (.mode64(mode64), .op(op), .rs1(rs1), .rs2(rs2), .result(result), .valid(valid));

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] ref_fn(input int f, input logic [63:0] x);
    case (f)
      0: return rr(x, 1) ^ rr(x, 8) ^ (x >> 7);
      1: return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
      2: return rr(x, 28) ^ rr(x, 34) ^ rr(x, 39);
      default: return rr(x, 14) ^ rr(x, 18) ^ rr(x, 41);
    endcase
  endfunction

  task automatic drive(input logic m, input logic [3:0] o, input logic [63:0] a, input logic [63:0] b);
    @(posedge clk);
    #1;
    mode64 = m; op = o; rs1 = a; rs2 = b;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] exp_r, input logic exp_v);
    n_chk++;
    if (result !== exp_r || valid !== exp_v) begin
      n_bad++;
      $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b", req, result, valid, exp_r, exp_v);
    end
  endtask

  task automatic test_word(input logic [63:0] w);
    logic [63:0] junk = {$urandom, $urandom};
    logic [63:0] f;
    logic [31:0] hi, lo;
    // R1, R2, R3: 64-bit forms (rs2 carries junk)
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 4'(k), w, junk);
      check(k == 0 ? "R1" : (k == 1 ? "R2" : "R3"), ref_fn(k, w), 1'b1);
    end
    // R4: sigma halves, upper source bits junk (R6)
    for (int s = 0; s < 2; s++) begin
      f = ref_fn(s, w);
      drive(1'b0, 4'(4 + 2*s), {junk[63:32], w[63:32]}, {~junk[63:32], w[31:0]});
      hi = result[31:0];
      check("R4_hi", {32'h0, f[63:32]}, 1'b1);
      drive(1'b0, 4'(5 + 2*s), {~junk[63:32], w[31:0]}, {junk[63:32], w[63:32]});
      lo = result[31:0];
      check("R4_lo", {32'h0, f[31:0]}, 1'b1);
      n_chk++;
      if ({hi, lo} !== f) begin
        n_bad++;
        $display("FAIL R4_join: got=%h expected=%h", {hi, lo}, f);
      end
    end
    // R5: sum register-pair, both operand orders
    for (int s = 0; s < 2; s++) begin
      f = ref_fn(2 + s, w);
      drive(1'b0, 4'(8 + s), {junk[31:0], w[63:32]}, {junk[63:32], w[31:0]});
      check("R5_hi", {32'h0, f[63:32]}, 1'b1);
      drive(1'b0, 4'(8 + s), {junk[63:32], w[31:0]}, {junk[31:0], w[63:32]});
      check("R5_lo", {32'h0, f[31:0]}, 1'b1);
    end
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: expired after %0d cycles, expected completion", cycles);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    mode64 = 1'b1; op = 4'd15; rs1 = '0; rs2 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: illegal code idles output at zero
    check("R7_idle", 64'h0, 1'b0);

    // R8: output follows input with no clock edge
    #1; mode64 = 1'b1; op = 4'd2; rs1 = 64'h0123_4567_89ab_cdef;
    #1; check("R8", ref_fn(2, 64'h0123_4567_89ab_cdef), 1'b1);

    test_word(64'h0);
    test_word(64'hffff_ffff_ffff_ffff);
    test_word(64'h1);
    test_word(64'h8000_0000);
    test_word(64'h1_0000_0000);
    test_word(64'h8000_0000_0000_0000);
    for (int i = 0; i < 24; i++) test_word({$urandom, $urandom});

    // R7: illegal codes in each mode
    for (int c = 4; c < 16; c++) begin
      drive(1'b1, 4'(c), 64'hdead_beef_cafe_f00d, 64'h1234_5678_9abc_def0);
      check("R7_m64", 64'h0, 1'b0);
    end
    for (int c = 0; c < 16; c++) begin
      if (c < 4 || c > 9) begin
        drive(1'b0, 4'(c), 64'hdead_beef_cafe_f00d, 64'h1234_5678_9abc_def0);
        check("R7_m32", 64'h0, 1'b0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule